// File: doc/BRIEF.md
# DMA Address and Direction Control Register

This block holds the control word for a bus-master channel that serves a SCSI protocol chip and moves data between that chip and system memory. A host CPU programs the word one byte at a time through a narrow write bus that has two ports. A write to the latch port opens a programming sequence and captures the top byte. The following writes go to the address port, most significant byte first. When the last byte of the sequence arrives, the assembled 32-bit word replaces the active one in a single step. A one-cycle load-done pulse follows.

In the active word, bit 31 gives the transfer direction and bits 30..0 give a word address, which is the buffer byte address shifted right by one. The memory side sees a byte address in which bit 0 is always zero. It also sees a direction flag. Every transfer-done strobe from the memory side moves the word address forward by one. A parameter selects between two variants. The full variant takes four address-port bytes, and its latch port sits at offset 0x8000. The reduced variant takes three address-port bytes, takes its top byte from the latch write, and has its latch port at offset 0x10.

Top module: `bm_addr_dir_reg`

## Requirements
- R1: After a synchronous reset, the active word is zero. `mem_addr` is 0, `mem_rd` is 0 and `load_done` is 0.
- R2: The address port is at bus offset 0. The latch port is at offset 0x8000 when FULL_SEQ=1 and at offset 0x10 when FULL_SEQ=0. A write to any other offset has no effect on a sequence that is in progress.
- R3: An address-port write that does not follow a latch write is ignored, and the active word and `load_done` stay unchanged. This covers writes after reset and writes after a sequence has completed.
- R4: A latch-port write always restarts the sequence at the first byte position, and any partial sequence is abandoned.
- R5: With FULL_SEQ=1, four address-port bytes form the word in the order bits 31..24, 23..16, 15..8, 7..0. The first of these bytes overrides the latched top byte.
- R6: With FULL_SEQ=0, three address-port bytes form bits 23..16, 15..8 and 7..0, in that order. Bits 31..24 come from the latch write.
- R7: The new word takes effect on the clock edge of the final byte write. `load_done` is high for exactly the following cycle. Before that edge, the previous word stays on the outputs.
- R8: `mem_rd` equals bit 31 of the active word. The value 1 means memory is read and the data goes to the device. The value 0 means device data is written to memory.
- R9: `mem_addr` equals bits 30..0 of the active word shifted left by one, with bit 0 equal to 0.
- R10: Each cycle in which `xfer_done` is high adds 1 to the 31-bit word address, modulo 2^31, and leaves the direction bit unchanged.
- R11: If `xfer_done` coincides with the final byte write, the newly loaded word is taken exactly as written and that strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Byte write strobe from the host |
| bus_addr | input | PORT_AW | Byte offset of the write |
| bus_wdata | input | 8 | Write data byte |
| xfer_done | input | 1 | One word transferred on the memory side |
| mem_addr | output | WORD_W | Current memory byte address, bit 0 always 0 |
| mem_rd | output | 1 | Direction: 1 = memory to device, 0 = device to memory |
| load_done | output | 1 | One-cycle pulse after a new word has been loaded |

## Verification
Two functions can act in the same cycle: loading a new word and incrementing the address on a memory-side strobe. The bench provokes this by raising `xfer_done` on the cycle of the final address-port byte. It then judges the result by requiring the outputs to show the written word with no increment applied. A second strobe afterwards must advance the word address by exactly one.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_ADDR  = 2'd2
  } port_sel_e;

  function automatic int seq_len(input int word_bytes, input bit full);
    return full ? word_bytes : word_bytes - 1;
  endfunction
endpackage

// File: rtl/dmaw_port_decode.sv
module dmaw_port_decode
  import dmaw_pkg::*;
#(
  parameter int PORT_AW   = 16,
  parameter int LATCH_OFS = 'h8000
) (
  input  logic               bus_wr,
  input  logic [PORT_AW-1:0] bus_addr,
  output port_sel_e          sel
);
  localparam logic [PORT_AW-1:0] LATCH_A = PORT_AW'(LATCH_OFS);
  localparam logic [PORT_AW-1:0] ADDR_A  = '0;

  always_comb begin
    sel = SEL_NONE;
    if (bus_wr) begin
      if (bus_addr == LATCH_A)     sel = SEL_LATCH;
      else if (bus_addr == ADDR_A) sel = SEL_ADDR;
    end
  end
endmodule

// File: rtl/dmaw_byte_assembler.sv
module dmaw_byte_assembler
  import dmaw_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter bit FULL_SEQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  port_sel_e         sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              commit,
  output logic [WORD_W-1:0] word_next
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int NSEQ   = seq_len(NBYTES, FULL_SEQ);
  localparam int IDX_W  = (NSEQ > 1) ? $clog2(NSEQ) : 1;
  localparam int LANE0  = NSEQ - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSEQ - 1);

  logic [WORD_W-1:0] shadow;
  logic [IDX_W-1:0]  idx;
  logic              armed;
  int                lane;

  always_comb begin
    lane      = LANE0 - int'(idx);
    word_next = shadow;
    word_next[lane*BYTE_W +: BYTE_W] = wdata;
    commit    = (sel == SEL_ADDR) && armed && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      idx    <= '0;
      armed  <= 1'b0;
    end else if (sel == SEL_LATCH) begin
      shadow[WORD_W-1 -: BYTE_W] <= wdata;
      idx   <= '0;
      armed <= 1'b1;
    end else if (sel == SEL_ADDR && armed) begin
      shadow[lane*BYTE_W +: BYTE_W] <= wdata;
      if (idx == LAST_IDX) begin
        idx   <= '0;
        armed <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R3: a stray address-port write must leave the partial word untouched
  assert_orphan_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_ADDR && !armed) |=> $stable(shadow));

  // R4: a latch write restarts at the first position with the sequence open
  assert_latch_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_LATCH) |=> (armed && idx == '0));
endmodule

// File: rtl/dmaw_addr_counter.sv
module dmaw_addr_counter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              inc,
  output logic [WORD_W-1:0] word,
  output logic              loaded
);
  localparam int AW = WORD_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      word   <= '0;
      loaded <= 1'b0;
    end else begin
      loaded <= load;
      if (load)     word <= din;
      else if (inc) word <= {word[WORD_W-1], word[AW-1:0] + AW'(1)};
    end
  end

  // R7: with no load and no strobe the active word holds
  assert_hold_word_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc) |=> $stable(word));

  // R10: a strobe advances the address by one and keeps the direction
  assert_inc_step_R10: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (word[AW-1:0] == $past(word[AW-1:0]) + AW'(1))
                       && (word[WORD_W-1] == $past(word[WORD_W-1])));

  // R11: a load takes the written value exactly, even with a strobe present
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (word == $past(din)));
endmodule

// File: rtl/bm_addr_dir_reg.sv
module bm_addr_dir_reg
  import dmaw_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int PORT_AW  = 16,
  parameter bit FULL_SEQ = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [PORT_AW-1:0] bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               xfer_done,
  output logic [WORD_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               load_done
);
  localparam int LATCH_OFS = FULL_SEQ ? 'h8000 : 'h10;

  port_sel_e         sel;
  logic              commit;
  logic [WORD_W-1:0] word_next;
  logic [WORD_W-1:0] word;

  dmaw_port_decode #(.PORT_AW(PORT_AW), .LATCH_OFS(LATCH_OFS)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .sel(sel)
  );

  dmaw_byte_assembler #(.WORD_W(WORD_W), .FULL_SEQ(FULL_SEQ)) u_asm (
    .clk(clk), .rst(rst), .sel(sel), .wdata(bus_wdata),
    .commit(commit), .word_next(word_next)
  );

  dmaw_addr_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .load(commit), .din(word_next), .inc(xfer_done),
    .word(word), .loaded(load_done)
  );

  assign mem_addr = {word[WORD_W-2:0], 1'b0};
  assign mem_rd   = word[WORD_W-1];

  // R7: load_done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);

  // R9: byte address bit 0 stays zero whatever the history
  assert_addr_even_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_done || load_done) |=> (mem_addr[0] == 1'b0));
endmodule

// File: tb/tb_bm_addr_dir_reg.sv
module tb_bm_addr_dir_reg;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_f = 0, wr_r = 0;
  logic [15:0] baddr = '0;
  logic [7:0]  bdata = '0;
  logic        xd_f = 0, xd_r = 0;
  logic [31:0] ma_f, ma_r;
  logic        rd_f, rd_r, ld_f, ld_r;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  bm_addr_dir_reg #(.FULL_SEQ(1'b1)) dut (
    .clk(clk), .rst(rst), .bus_wr(wr_f), .bus_addr(baddr), .bus_wdata(bdata),
    .xfer_done(xd_f), .mem_addr(ma_f), .mem_rd(rd_f), .load_done(ld_f));

  bm_addr_dir_reg #(.FULL_SEQ(1'b0)) dut_red (
    .clk(clk), .rst(rst), .bus_wr(wr_r), .bus_addr(baddr), .bus_wdata(bdata),
    .xfer_done(xd_r), .mem_addr(ma_r), .mem_rd(rd_r), .load_done(ld_r));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one byte write; returns after the edge, sampled at the next negedge
  task automatic wr(input bit red, input logic [15:0] a, input logic [7:0] d,
                    input bit strobe = 0);
    baddr = a; bdata = d;
    if (red) begin wr_r = 1; xd_r = strobe; end
    else     begin wr_f = 1; xd_f = strobe; end
    @(negedge clk);
    wr_f = 0; wr_r = 0; xd_f = 0; xd_r = 0;
  endtask

  task automatic load_full(input logic [31:0] w);
    wr(0, 16'h8000, 8'h00);
    for (int i = 3; i >= 0; i--) wr(0, 16'h0000, w[i*8 +: 8]);
  endtask

  task automatic strobe_f();
    xd_f = 1; @(negedge clk); xd_f = 0;
  endtask

  task automatic t_reset();
    chk("R1 mem_addr full", ma_f, 0);
    chk("R1 mem_rd full", {31'b0, rd_f}, 0);
    chk("R1 load_done full", {31'b0, ld_f}, 0);
    chk("R1 mem_addr reduced", ma_r, 0);
  endtask

  task automatic t_orphan_after_reset();
    for (int i = 0; i < 4; i++) wr(0, 16'h0000, 8'hA5);
    chk("R3 no load after reset", ma_f, 0);
    chk("R3 no pulse after reset", {31'b0, ld_f}, 0);
  endtask

  task automatic t_full_load();
    wr(0, 16'h8000, 8'h00);
    wr(0, 16'h0000, 8'h81);
    wr(0, 16'h0000, 8'h23);
    wr(0, 16'h0000, 8'h45);
    chk("R7 old word held", ma_f, 0);
    chk("R7 no early pulse", {31'b0, ld_f}, 0);
    wr(0, 16'h0000, 8'h67);
    chk("R5 R9 mem_addr", ma_f, 32'h0246_8ACE);
    chk("R5 R8 dir from first byte", {31'b0, rd_f}, 1);
    chk("R7 pulse", {31'b0, ld_f}, 1);
    @(negedge clk);
    chk("R7 pulse ends", {31'b0, ld_f}, 0);
  endtask

  task automatic t_orphan_after_commit();
    for (int i = 0; i < 4; i++) wr(0, 16'h0000, 8'h11);
    chk("R3 word kept after commit", ma_f, 32'h0246_8ACE);
    chk("R3 no pulse after commit", {31'b0, ld_f}, 0);
  endtask

  task automatic t_red_load();
    wr(1, 16'h0010, 8'h12);
    wr(1, 16'h0000, 8'h34);
    wr(1, 16'h0000, 8'h56);
    wr(1, 16'h0000, 8'h78);
    chk("R6 reduced mem_addr", ma_r, 32'h2468_ACF0);
    chk("R6 R8 reduced dir", {31'b0, rd_r}, 0);
    chk("R2 R7 reduced pulse", {31'b0, ld_r}, 1);
  endtask

  task automatic t_restart();
    wr(0, 16'h8000, 8'hFF);
    wr(0, 16'h0000, 8'hFF);
    wr(0, 16'h0000, 8'hFF);
    wr(0, 16'h8000, 8'h00);
    wr(0, 16'h0000, 8'h00);
    wr(0, 16'h0000, 8'h00);
    chk("R4 no commit mid restart", {31'b0, ld_f}, 0);
    wr(0, 16'h0000, 8'h10);
    wr(0, 16'h0000, 8'h00);
    chk("R4 restarted word", ma_f, 32'h0000_2000);
    chk("R4 restarted dir", {31'b0, rd_f}, 0);
  endtask

  task automatic t_decode();
    wr(0, 16'h8000, 8'h00);
    wr(0, 16'h0000, 8'h00);
    wr(0, 16'h0000, 8'h00);
    wr(0, 16'h0010, 8'hEE);
    wr(0, 16'h1234, 8'hDD);
    wr(0, 16'h0000, 8'h01);
    chk("R2 other offsets not counted", {31'b0, ld_f}, 0);
    wr(0, 16'h0000, 8'h02);
    chk("R2 word after stray offsets", ma_f, 32'h0000_0204);
  endtask

  task automatic t_increment();
    load_full(32'h8000_0100);
    strobe_f(); strobe_f(); strobe_f();
    chk("R10 three steps", ma_f, 32'h0000_0206);
    chk("R10 dir kept", {31'b0, rd_f}, 1);
    load_full(32'h7FFF_FFFF);
    strobe_f();
    chk("R10 wrap dir0", ma_f, 0);
    chk("R10 wrap dir0 dir", {31'b0, rd_f}, 0);
    load_full(32'hFFFF_FFFF);
    strobe_f();
    chk("R10 wrap dir1 addr", ma_f, 0);
    chk("R10 wrap dir1 dir", {31'b0, rd_f}, 1);
  endtask

  task automatic t_collide();
    wr(0, 16'h8000, 8'h00);
    wr(0, 16'h0000, 8'h00);
    wr(0, 16'h0000, 8'h00);
    wr(0, 16'h0000, 8'h00);
    wr(0, 16'h0000, 8'h40, 1'b1);
    chk("R11 load wins over strobe", ma_f, 32'h0000_0080);
    strobe_f();
    chk("R11 later strobe counts", ma_f, 32'h0000_0082);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_orphan_after_reset();
    t_full_load();
    t_orphan_after_commit();
    t_red_load();
    t_restart();
    t_decode();
    t_increment();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule